// File: doc/BRIEF.md
# Converter Result Bus Formatter

This block sits between a 12-bit converter and a shared 12-line bidirectional pin bus. Each result arrives with a one-cycle valid strobe. The block latches the result into a holding register and presents it on the bus in one of two styles. In full-width style all twelve lines carry the word. In byte style the word is split across two half-periods on the upper eight lines, and the block reports which half is present. The pad cells outside the block apply a per-line drive value and enable.

The enables follow the pins directly. An output-disable pin releases every line. In parallel control mode, a low read/write signal releases the upper eight lines so that control bytes can come in on them. A high read/write signal lets those lines drive again. The style selection is sampled only when a new result is captured, so a word is always sent whole in the style that was selected when it arrived.

Top module: `conv_bus_formatter`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, bus_do is zero and half_phase is 0.
- R2: While out_disable is 1, all twelve bits of bus_oe are 0, whatever the other inputs are, in the same cycle.
- R3: While out_disable is 0 and the bus is not in control-input state, all twelve bits of bus_oe are 1.
- R4: While out_disable is 0, par_mode is 1 and rd_nwr is 0, bus_oe[11:4] are 0 and bus_oe[3:0] are 1.
- R5: While out_disable is 0, par_mode is 1 and rd_nwr is 1, all twelve bits of bus_oe are 1.
- R6: When a strobe is taken with byte_mode 0 (full style), bus_do equals the sampled word from the next cycle on, with bit 11 as MSB and bit 0 as LSB, and half_phase stays 0.
- R7: When a strobe is taken with byte_mode 1 (byte style), bus_do equals {word[11:4], 4'b0000} and half_phase is 0 from the next cycle on, for HALF_CYC cycles.
- R8: In byte style, HALF_CYC clock edges after the edge that captured the strobe, bus_do becomes {word[3:0], 8'b0} and half_phase becomes 1. bus_do[3:0] are 0 throughout byte style.
- R9: byte_mode is sampled only on a strobe. A change between strobes does not alter the style of the word being sent.
- R10: Without a strobe, changes on sample_data do not alter bus_do.
- R11: A strobe that arrives during the first half of a byte-style word restarts output with the new word's high half. The low half then follows HALF_CYC edges after the new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle strobe marking a new result |
| sample_data | input | 12 | Converter result word |
| byte_mode | input | 1 | 0 = full-width style, 1 = byte-split style |
| out_disable | input | 1 | 1 releases all twelve lines |
| par_mode | input | 1 | 1 when configuration uses the parallel control port |
| rd_nwr | input | 1 | Parallel direction: 0 = upper lines take control data in |
| bus_do | output | 12 | Drive value for each bus line |
| bus_oe | output | 12 | Drive enable for each bus line |
| half_phase | output | 1 | 0 = high half or full word on bus, 1 = low half |

## Verification
The drive enables are combinational from the pins. They are checked a few time units after the inputs change, with no clock edge in between. Data and half_phase are registered. A captured word is checked one edge after its strobe, and again after the next edge, where the high half must still be present. The low half is checked after the edge HALF_CYC edges past the capture. Inputs are changed on falling edges and sampled on the next falling edge, so every expected value lines up with a known count of rising edges.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_BYTE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/fmt_hold.sv
module fmt_hold
  import fmt_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int UPPER_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  out_mode_e         mode_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              advance,
  output out_mode_e         mode_q,
  output logic [DATA_W-1:0] dout_q
);
  localparam int LOWER_W = DATA_W - UPPER_W;
  localparam int PAD_W   = UPPER_W - LOWER_W;

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] first_half;
  logic [DATA_W-1:0] second_half;

  always_comb begin
    if (mode_in == MODE_BYTE)
      first_half = {data_in[DATA_W-1:LOWER_W], {LOWER_W{1'b0}}};
    else
      first_half = data_in;
    second_half = {hold_q[LOWER_W-1:0], {PAD_W{1'b0}}, {LOWER_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      dout_q <= '0;
      mode_q <= MODE_FULL;
    end else if (load) begin
      hold_q <= data_in;
      dout_q <= first_half;
      mode_q <= mode_in;
    end else if (advance) begin
      dout_q <= second_half;
    end
  end

  assert_mode_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mode_q));
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(dout_q));
  assert_full_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load && mode_in == MODE_FULL) |=> dout_q == $past(data_in));
  assert_byte_load_R7: assert property (@(posedge clk) disable iff (rst)
    (load && mode_in == MODE_BYTE) |=>
      dout_q[DATA_W-1:LOWER_W] == $past(data_in[DATA_W-1:LOWER_W]));
  assert_low_half_R8: assert property (@(posedge clk) disable iff (rst)
    advance |=> dout_q[DATA_W-1:DATA_W-LOWER_W] == $past(hold_q[LOWER_W-1:0]));
  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BYTE) |-> dout_q[LOWER_W-1:0] == '0);
endmodule

// File: rtl/fmt_phase.sv
module fmt_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic byte_q,
  output logic advance,
  output logic phase_q
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign advance = byte_q && !phase_q && !load && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (advance) begin
      phase_q <= 1'b1;
    end else if (byte_q && !phase_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> !phase_q);
  assert_phase_full_R6: assert property (@(posedge clk) disable iff (rst)
    !byte_q |-> !phase_q);
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q && !load) |=> phase_q);
endmodule

// File: rtl/fmt_dir.sv
module fmt_dir #(
  parameter int DATA_W  = 12,
  parameter int UPPER_W = 8
) (
  input  logic              out_disable,
  input  logic              par_mode,
  input  logic              rd_nwr,
  output logic [DATA_W-1:0] oe
);
  localparam int LOWER_W = DATA_W - UPPER_W;

  logic ctrl_in;
  assign ctrl_in = par_mode && !rd_nwr;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_line
    if (gi >= LOWER_W) begin : g_upper
      assign oe[gi] = !out_disable && !ctrl_in;
    end else begin : g_lower
      assign oe[gi] = !out_disable;
    end
  end
endmodule

// File: rtl/conv_bus_formatter.sv
module conv_bus_formatter
  import fmt_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int UPPER_W  = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  input  logic              byte_mode,
  input  logic              out_disable,
  input  logic              par_mode,
  input  logic              rd_nwr,
  output logic [DATA_W-1:0] bus_do,
  output logic [DATA_W-1:0] bus_oe,
  output logic              half_phase
);
  localparam int LOWER_W = DATA_W - UPPER_W;

  out_mode_e mode_in;
  out_mode_e mode_q;
  logic      advance;

  assign mode_in = byte_mode ? MODE_BYTE : MODE_FULL;

  fmt_hold #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (sample_valid),
    .mode_in (mode_in),
    .data_in (sample_data),
    .advance (advance),
    .mode_q  (mode_q),
    .dout_q  (bus_do)
  );

  fmt_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .load    (sample_valid),
    .byte_q  (mode_q == MODE_BYTE),
    .advance (advance),
    .phase_q (half_phase)
  );

  fmt_dir #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) u_dir (
    .out_disable (out_disable),
    .par_mode    (par_mode),
    .rd_nwr      (rd_nwr),
    .oe          (bus_oe)
  );

  assert_phase_data_R8: assert property (@(posedge clk) disable iff (rst)
    half_phase |-> bus_do[UPPER_W-1:0] == '0);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (bus_do == '0 && !half_phase));
  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (!out_disable && par_mode && !rd_nwr) |-> bus_oe[LOWER_W-1:0] == '1);
endmodule

// File: tb/tb_conv_bus_formatter.sv
module tb_conv_bus_formatter;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [11:0] sample_data = '0;
  logic        byte_mode = 1'b0;
  logic        out_disable = 1'b0;
  logic        par_mode = 1'b0;
  logic        rd_nwr = 1'b1;
  logic [11:0] bus_do;
  logic [11:0] bus_oe;
  logic        half_phase;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  conv_bus_formatter #(.DATA_W(12), .UPPER_W(8), .HALF_CYC(HALF)) dut (
    .clk, .rst, .sample_valid, .sample_data, .byte_mode,
    .out_disable, .par_mode, .rd_nwr, .bus_do, .bus_oe, .half_phase
  );

  // {byte_mode, word, first value on bus, value after HALF edges}
  localparam logic [36:0] VEC [7] = '{
    {1'b0, 12'hA5C, 12'hA5C, 12'hA5C},
    {1'b1, 12'hA5C, 12'hA50, 12'hC00},
    {1'b0, 12'hFFF, 12'hFFF, 12'hFFF},
    {1'b1, 12'hFFF, 12'hFF0, 12'hF00},
    {1'b1, 12'h001, 12'h000, 12'h100},
    {1'b0, 12'h000, 12'h000, 12'h000},
    {1'b1, 12'h8F3, 12'h8F0, 12'h300}
  };

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic strobe(input logic m, input logic [11:0] d);
    sample_valid = 1'b1;
    sample_data  = d;
    byte_mode    = m;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset data", bus_do, 12'h000);
    check("R1 reset phase", {11'b0, half_phase}, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", bus_do, 12'h000);
    check("R3 enables", bus_oe, 12'hFFF);

    for (int i = 0; i < 7; i++) begin
      strobe(VEC[i][36], VEC[i][35:24]);
      check(VEC[i][36] ? "R7 high half" : "R6 full word", bus_do, VEC[i][23:12]);
      check("R7 phase first", {11'b0, half_phase}, 12'h000);
      @(negedge clk);
      check(VEC[i][36] ? "R7 high half held" : "R6 full held", bus_do, VEC[i][23:12]);
      @(negedge clk);
      check(VEC[i][36] ? "R8 low half" : "R6 full still", bus_do, VEC[i][11:0]);
      check("R8 phase second", {11'b0, half_phase}, {11'b0, VEC[i][36]});
    end

    // R9: mode change mid-word in byte style
    strobe(1'b1, 12'h5A6);
    byte_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 byte kept", bus_do, 12'h600);
    check("R9 byte phase", {11'b0, half_phase}, 12'h001);
    // R9: mode change between strobes in full style
    strobe(1'b0, 12'h321);
    byte_mode = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 full kept", bus_do, 12'h321);
    check("R9 full phase", {11'b0, half_phase}, 12'h000);
    // R10: data change without strobe
    sample_data = 12'hFFF;
    @(negedge clk);
    check("R10 data ignored", bus_do, 12'h321);

    // R11: strobe during the first half
    strobe(1'b1, 12'h123);
    check("R11 first high", bus_do, 12'h120);
    strobe(1'b1, 12'hABC);
    check("R11 restart high", bus_do, 12'hAB0);
    check("R11 restart phase", {11'b0, half_phase}, 12'h000);
    @(negedge clk);
    check("R11 high held", bus_do, 12'hAB0);
    @(negedge clk);
    check("R11 low half", bus_do, 12'hC00);
    check("R11 low phase", {11'b0, half_phase}, 12'h001);

    // direction control
    out_disable = 1'b1; par_mode = 1'b1; rd_nwr = 1'b0;
    #1 check("R2 all released", bus_oe, 12'h000);
    out_disable = 1'b0;
    #1 check("R4 upper released", bus_oe, 12'h00F);
    rd_nwr = 1'b1;
    #1 check("R5 upper driven", bus_oe, 12'hFFF);
    par_mode = 1'b0; rd_nwr = 1'b0;
    #1 check("R3 serial control drives", bus_oe, 12'hFFF);
    out_disable = 1'b1;
    #1 check("R2 released serial", bus_oe, 12'h000);
    out_disable = 1'b0;

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", bus_do, 12'h000);
    check("R1 mid-run phase", {11'b0, half_phase}, 12'h000);
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule